// File: doc/BRIEF.md
# Serial Audio Receiver with Byte-Lane Memory Writer

This block takes a stereo serial audio stream from a converter (bit clock, word select and serial data, framed as I2S) and turns each 24-bit sample into three byte-wide write beats for an audio memory. The memory is 16 bits wide. The sample byte goes on the low lane and the high lane is held at all ones, so one sample fills three consecutive memory words.

The serial front end runs on the bit clock. At the standard rate, the bit clock is 64 times the frame rate: 2.8224 MHz for 44.1 kHz frames, taken from an 11.2896 MHz (256x) reference. When a sample is complete, it is held in a register and announced by flipping a toggle flag. The system clock side passes that flag through a short synchronizer chain and loads the held sample into a byte serializer. The serializer then drives one beat per system cycle, most significant byte first, each beat tagged with its byte index and its channel.

A word-select transition always restarts the receiver. If a transition arrives before all 24 data bits of a channel are in, the partial sample is dropped.

Top module: `i2s_byte_writer`

## Requirements
- R1: While `rst_n` is low and after it is released, `wr_valid` is 0 and `wr_data` reads 16'hFF00 until the first sample is emitted.
- R2: Capture starts on the second bit-clock rising edge after a word-select change, so the bit that arrives with the change is ignored. The next 24 bits are captured MSB first as sample bits 23 down to 0.
- R3: A sample captured while word select is 0 is tagged `wr_chan` = 0 (left). While word select is 1 it is tagged `wr_chan` = 1 (right).
- R4: Each sample produces exactly three beats in three consecutive system cycles, with `wr_idx` equal to 2, then 1, then 0.
- R5: The beat with `wr_idx` = k carries sample bits [8k+7:8k] on `wr_data[7:0]`.
- R6: On every beat, `wr_data[15:8]` is 8'hFF.
- R7: Samples are emitted once each, in the order they completed on the serial line. With a regular stream this alternates left, then right.
- R8: If word select changes before the 24th data bit of a channel is captured, that partial sample is discarded and produces no beats. This includes a change that lands on the same bit-clock edge as the 24th bit.
- R9: After reset, no sample is captured until word select has changed at least once.
- R10: Serial bits after the 24th data bit of a channel slot, up to the next word-select change, have no effect on any beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | System clock for the memory write side |
| rst_n | input | 1 | Active-low asynchronous reset for both clock domains |
| bclk | input | 1 | Serial bit clock (64 x frame rate) |
| ws | input | 1 | Word select: 0 = left, 1 = right |
| sdata | input | 1 | Serial audio data, sampled on the bit clock rising edge |
| wr_valid | output | 1 | A write beat is present this system cycle |
| wr_idx | output | 2 | Byte index of the beat: 2 = most significant, 0 = least |
| wr_chan | output | 1 | Channel of the sample being written: 0 = left, 1 = right |
| wr_data | output | 16 | Memory write word: 8'hFF above the sample byte |

## Verification
Two functions of the serial front end can fall on the same bit-clock edge: the word-select change that restarts a frame, and the arrival of the 24th data bit that completes a sample. When they coincide, the restart wins and the sample is lost. The bench provokes this by sending a channel slot of exactly 24 bit periods, so the next change lands where the last data bit would be. It then sends a slot of 25 periods, where the sample just completes. The case is judged at the write port: the first slot must give no beats and the second must give its three bytes, with channel and order correct.

// File: rtl/i2sb_pkg.sv
package i2sb_pkg;

    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

    localparam int unsigned DEF_SAMPLE_W = 24;
    localparam int unsigned DEF_BYTE_W   = 8;
    localparam int unsigned DEF_MEM_W    = 16;
    localparam int unsigned DEF_SYNC_N   = 2;

endpackage

// File: rtl/i2sb_capture.sv
module i2sb_capture
    import i2sb_pkg::*;
#(
    parameter int unsigned SAMPLE_W = DEF_SAMPLE_W
) (
    input  logic                bclk,
    input  logic                rst_n,
    input  logic                ws,
    input  logic                sdata,
    output logic [SAMPLE_W-1:0] smp_data,
    output chan_e               smp_chan,
    output logic                smp_tog
);

    localparam int unsigned CNT_W = $clog2(SAMPLE_W + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SAMPLE_W - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(SAMPLE_W);

    typedef struct packed {
        logic                ws_seen;
        logic                armed;
        logic [CNT_W-1:0]    cnt;
        logic [SAMPLE_W-1:0] shift;
        chan_e               chan;
        logic [SAMPLE_W-1:0] held;
        chan_e               held_chan;
        logic                tog;
    } cap_t;

    cap_t cap_d, cap_q;
    logic [SAMPLE_W-1:0] shifted;

    always_comb begin
        cap_d         = cap_q;
        cap_d.ws_seen = ws;
        shifted       = {cap_q.shift[SAMPLE_W-2:0], sdata};
        if (ws != cap_q.ws_seen) begin
            // channel boundary: restart, bit on this edge belongs to the old slot
            cap_d.armed = 1'b1;
            cap_d.cnt   = '0;
            cap_d.shift = '0;
            cap_d.chan  = chan_e'(ws);
        end else if (cap_q.armed && (cap_q.cnt < CNT_FULL)) begin
            cap_d.shift = shifted;
            cap_d.cnt   = cap_q.cnt + 1'b1;
            if (cap_q.cnt == CNT_LAST) begin
                cap_d.held      = shifted;
                cap_d.held_chan = cap_q.chan;
                cap_d.tog       = ~cap_q.tog;
            end
        end
    end

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '{ws_seen: 1'b0, armed: 1'b0, cnt: '0, shift: '0,
                       chan: CH_LEFT, held: '0, held_chan: CH_LEFT, tog: 1'b0};
        end else begin
            cap_q <= cap_d;
        end
    end

    assign smp_data = cap_q.held;
    assign smp_chan = cap_q.held_chan;
    assign smp_tog  = cap_q.tog;

    // R9: a sample is only published once a word-select change has armed capture
    a_r9_armed_before_publish : assert property (@(posedge bclk) disable iff (!rst_n)
        (cap_q.tog != $past(cap_q.tog)) |-> $past(cap_q.armed));

    // R8: a sample is only published after exactly SAMPLE_W bits with no restart
    a_r8_full_word_only : assert property (@(posedge bclk) disable iff (!rst_n)
        (cap_q.tog != $past(cap_q.tog)) |-> ($past(cap_q.cnt) == CNT_LAST));

    // R2: a restart always leaves the bit counter at zero
    a_r2_restart_clears : assert property (@(posedge bclk) disable iff (!rst_n)
        (ws != cap_q.ws_seen) |=> (cap_q.cnt == '0));

endmodule

// File: rtl/i2sb_toggle_sync.sv
module i2sb_toggle_sync
    import i2sb_pkg::*;
#(
    parameter int unsigned STAGES = DEF_SYNC_N
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tog_in,
    output logic pulse
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d       = sync_q;
        sync_d.chain = {sync_q.chain[STAGES-2:0], tog_in};
        sync_d.last  = sync_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '{chain: '0, last: 1'b0};
        end else begin
            sync_q <= sync_d;
        end
    end

    assign pulse = sync_q.chain[STAGES-1] ^ sync_q.last;

    // R7: one flip of the toggle yields one single-cycle load request
    a_r7_pulse_isolated : assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

endmodule

// File: rtl/i2sb_serializer.sv
module i2sb_serializer
    import i2sb_pkg::*;
#(
    parameter int unsigned SAMPLE_W = DEF_SAMPLE_W,
    parameter int unsigned BYTE_W   = DEF_BYTE_W,
    parameter int unsigned MEM_W    = DEF_MEM_W
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 load,
    input  logic [SAMPLE_W-1:0]                  in_data,
    input  chan_e                                in_chan,
    output logic                                 out_valid,
    output logic [$clog2(SAMPLE_W/BYTE_W)-1:0]   out_idx,
    output chan_e                                out_chan,
    output logic [MEM_W-1:0]                     out_word
);

    localparam int unsigned NUM_BYTES = SAMPLE_W / BYTE_W;
    localparam int unsigned IDX_W     = $clog2(NUM_BYTES);
    localparam int unsigned PAD_W     = MEM_W - BYTE_W;
    localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(NUM_BYTES - 1);

    typedef struct packed {
        logic                busy;
        logic [IDX_W-1:0]    idx;
        logic [SAMPLE_W-1:0] data;
        chan_e               chan;
    } ser_t;

    ser_t ser_d, ser_q;
    logic [BYTE_W-1:0] lane;

    always_comb begin
        ser_d = ser_q;
        if (load) begin
            ser_d.busy = 1'b1;
            ser_d.idx  = IDX_TOP;
            ser_d.data = in_data;
            ser_d.chan = in_chan;
        end else if (ser_q.busy) begin
            if (ser_q.idx == '0) begin
                ser_d.busy = 1'b0;
            end else begin
                ser_d.idx = ser_q.idx - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ser_q <= '{busy: 1'b0, idx: '0, data: '0, chan: CH_LEFT};
        end else begin
            ser_q <= ser_d;
        end
    end

    always_comb begin
        lane = '0;
        for (int i = 0; i < NUM_BYTES; i++) begin
            if (ser_q.idx == IDX_W'(i)) begin
                lane = ser_q.data[i*BYTE_W +: BYTE_W];
            end
        end
    end

    generate
        if (PAD_W > 0) begin : g_padded
            assign out_word = {{PAD_W{1'b1}}, lane};
        end else begin : g_exact
            assign out_word = lane;
        end
    endgenerate

    assign out_valid = ser_q.busy;
    assign out_idx   = ser_q.idx;
    assign out_chan  = ser_q.chan;

    // R4: a load starts a beat run at the top byte
    a_r4_start_at_top : assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (ser_q.busy && (ser_q.idx == IDX_TOP)));

    // R4: within a run the index steps down by one each cycle without a gap
    a_r4_countdown : assert property (@(posedge clk) disable iff (!rst_n)
        (ser_q.busy && (ser_q.idx != '0)) |=>
            (ser_q.busy && (ser_q.idx == $past(ser_q.idx) - 1'b1)));

    // R5: the sample held for serialization does not change mid-run
    a_r5_sample_held : assert property (@(posedge clk) disable iff (!rst_n)
        (ser_q.busy && (ser_q.idx != '0)) |=> $stable(ser_q.data));

    // R7: a new sample never lands on a run that still has bytes to send
    a_r7_no_overrun : assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (!ser_q.busy || (ser_q.idx == '0)));

endmodule

// File: rtl/i2s_byte_writer.sv
module i2s_byte_writer
    import i2sb_pkg::*;
#(
    parameter int unsigned SAMPLE_W    = DEF_SAMPLE_W,
    parameter int unsigned BYTE_W      = DEF_BYTE_W,
    parameter int unsigned MEM_W       = DEF_MEM_W,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_N
) (
    input  logic                                 sys_clk,
    input  logic                                 rst_n,
    input  logic                                 bclk,
    input  logic                                 ws,
    input  logic                                 sdata,
    output logic                                 wr_valid,
    output logic [$clog2(SAMPLE_W/BYTE_W)-1:0]   wr_idx,
    output logic                                 wr_chan,
    output logic [MEM_W-1:0]                     wr_data
);

    logic [SAMPLE_W-1:0] cap_data;
    chan_e               cap_chan;
    logic                cap_tog;
    logic                load_pulse;
    chan_e               out_chan;

    i2sb_capture #(
        .SAMPLE_W (SAMPLE_W)
    ) u_capture (
        .bclk     (bclk),
        .rst_n    (rst_n),
        .ws       (ws),
        .sdata    (sdata),
        .smp_data (cap_data),
        .smp_chan (cap_chan),
        .smp_tog  (cap_tog)
    );

    i2sb_toggle_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (sys_clk),
        .rst_n  (rst_n),
        .tog_in (cap_tog),
        .pulse  (load_pulse)
    );

    i2sb_serializer #(
        .SAMPLE_W (SAMPLE_W),
        .BYTE_W   (BYTE_W),
        .MEM_W    (MEM_W)
    ) u_serializer (
        .clk       (sys_clk),
        .rst_n     (rst_n),
        .load      (load_pulse),
        .in_data   (cap_data),
        .in_chan   (cap_chan),
        .out_valid (wr_valid),
        .out_idx   (wr_idx),
        .out_chan  (out_chan),
        .out_word  (wr_data)
    );

    assign wr_chan = out_chan;

endmodule

// File: tb/i2s_byte_writer_bench.sv
module i2s_byte_writer_bench;

    localparam int CLK_PERIOD  = 10;
    localparam int BCLK_PERIOD = 40;
    localparam int LOG_MAX     = 256;

    logic        sys_clk = 1'b0;
    logic        bclk    = 1'b0;
    logic        rst_n   = 1'b0;
    logic        ws      = 1'b0;
    logic        sdata   = 1'b0;
    logic        wr_valid;
    logic [1:0]  wr_idx;
    logic        wr_chan;
    logic [15:0] wr_data;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int log_n    = 0;
    logic [1:0]  log_idx  [LOG_MAX];
    logic        log_chan [LOG_MAX];
    logic [15:0] log_word [LOG_MAX];
    int          log_cyc  [LOG_MAX];

    always #(CLK_PERIOD/2)  sys_clk = ~sys_clk;
    always #(BCLK_PERIOD/2) bclk    = ~bclk;

    i2s_byte_writer u_i2s_byte_writer (
        .sys_clk  (sys_clk),
        .rst_n    (rst_n),
        .bclk     (bclk),
        .ws       (ws),
        .sdata    (sdata),
        .wr_valid (wr_valid),
        .wr_idx   (wr_idx),
        .wr_chan  (wr_chan),
        .wr_data  (wr_data)
    );

    // record every beat, sampled on the falling system edge
    always @(negedge sys_clk) begin
        cyc = cyc + 1;
        if (rst_n && wr_valid && log_n < LOG_MAX) begin
            log_idx[log_n]  = wr_idx;
            log_chan[log_n] = wr_chan;
            log_word[log_n] = wr_data;
            log_cyc[log_n]  = cyc;
            log_n = log_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint actual, input longint expected);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, actual, expected);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    // one channel slot: slot 0 carries the word-select change, slots 1..24 the sample
    task automatic send_chan(input logic wsv, input logic [23:0] smp,
                             input int nslots, input logic [31:0] fill);
        for (int s = 0; s < nslots; s++) begin
            @(negedge bclk);
            ws = wsv;
            if (s >= 1 && s <= 24) sdata = smp[24 - s];
            else                   sdata = fill[s];
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge bclk);
        repeat (8) @(negedge sys_clk);
    endtask

    task automatic expect_sample(input int k, input logic ch, input logic [23:0] smp,
                                 input string req);
        for (int j = 0; j < 3; j++) begin
            int e = k + j;
            int bi = 2 - j;
            check(log_idx[e] == 2'(bi), "R4", {req, " byte index"}, log_idx[e], bi);
            check(log_word[e][7:0] == smp[bi*8 +: 8], "R5", {req, " byte value"},
                  log_word[e][7:0], smp[bi*8 +: 8]);
            check(log_word[e][15:8] == 8'hFF, "R6", {req, " upper lane"},
                  log_word[e][15:8], 8'hFF);
            check(log_chan[e] == ch, "R3", {req, " channel"}, log_chan[e], ch);
            check(log_cyc[e] == log_cyc[k] + j, "R4", {req, " consecutive beats"},
                  log_cyc[e], log_cyc[k] + j);
        end
    endtask

    task automatic t_reset();
        @(negedge sys_clk);
        check(wr_valid == 1'b0, "R1", "valid in reset", wr_valid, 0);
        rst_n = 1'b1;
        repeat (6) @(negedge sys_clk);
        check(wr_valid == 1'b0, "R1", "valid after reset", wr_valid, 0);
        check(wr_data == 16'hFF00, "R1", "data after reset", wr_data, 16'hFF00);
        check(log_n == 0, "R1", "beats after reset", log_n, 0);
    endtask

    task automatic t_unarmed_start();
        int n0 = log_n;
        send_chan(1'b0, 24'h5A5A5A, 32, 32'hFFFF_FFFF);
        send_chan(1'b1, 24'hC3A501, 32, 32'h0000_0000);
        settle();
        check(log_n - n0 == 3, "R9", "beats before first edge excluded", log_n - n0, 3);
        if (log_n - n0 == 3) expect_sample(n0, 1'b1, 24'hC3A501, "R9");
    endtask

    task automatic t_stereo_stream();
        logic [23:0] pat [8];
        int n0 = log_n;
        pat[0] = 24'hABCDEF; pat[1] = 24'h123456;
        pat[2] = 24'h800001; pat[3] = 24'hFFFFFF;
        pat[4] = 24'h000000; pat[5] = 24'h7F80FE;
        pat[6] = 24'h0F0F0F; pat[7] = 24'hF0E1D2;
        for (int i = 0; i < 8; i++) begin
            send_chan(i[0], pat[i], 32, (i % 2 == 0) ? 32'hFFFF_FFFF : 32'hA5A5_A5A5);
        end
        settle();
        check(log_n - n0 == 24, "R7", "stream beat count", log_n - n0, 24);
        if (log_n - n0 == 24) begin
            for (int i = 0; i < 8; i++) begin
                expect_sample(n0 + 3*i, i[0], pat[i], "R2 R7 stream");
            end
        end
    endtask

    task automatic t_tail_bits_ignored();
        int n0 = log_n;
        send_chan(1'b0, 24'h3C96E1, 32, 32'h0000_0000);
        send_chan(1'b1, 24'h3C96E1, 32, 32'hFFFF_FFFF);
        settle();
        check(log_n - n0 == 6, "R10", "tail test beat count", log_n - n0, 6);
        if (log_n - n0 == 6) begin
            for (int j = 0; j < 3; j++) begin
                check(log_word[n0 + j] == log_word[n0 + 3 + j], "R10",
                      "tail bits alter byte", log_word[n0 + 3 + j], log_word[n0 + j]);
            end
            expect_sample(n0 + 3, 1'b1, 24'h3C96E1, "R10");
        end
    endtask

    task automatic t_short_slots();
        int n0 = log_n;
        send_chan(1'b0, 24'h111111, 24, 32'h0);       // change lands on 24th bit: lost
        send_chan(1'b1, 24'hE4D2B1, 32, 32'h0);
        send_chan(1'b0, 24'h222222, 16, 32'hFFFF_FFFF); // mid-sample change: lost
        send_chan(1'b1, 24'h9ABCDE, 25, 32'h0);       // just completes
        send_chan(1'b0, 24'h13579B, 32, 32'h0);
        settle();
        check(log_n - n0 == 9, "R8", "short slot beat count", log_n - n0, 9);
        if (log_n - n0 == 9) begin
            expect_sample(n0,     1'b1, 24'hE4D2B1, "R8 kept");
            expect_sample(n0 + 3, 1'b1, 24'h9ABCDE, "R8 edge-exact");
            expect_sample(n0 + 6, 1'b0, 24'h13579B, "R8 recover");
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (5) @(negedge bclk);
        t_reset();
        t_unarmed_start();
        t_stereo_stream();
        t_tail_bits_ignored();
        t_short_slots();
        summary();
    end

endmodule